// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block produces the pin-level timing of one external bus transaction at a time for an 8-bit processor core with a 16-bit address. A core-side request names a cycle kind, an address and, for writes, a data byte. The sequencer walks the cycle through its clock states. In the first state it drives the whole address and marks it with a one-cycle latch-enable pulse. It then either turns the shared low-byte pins around to read or drives the write byte. It asserts the matching strobe and stretches the cycle with wait states for as long as `ready` is low.

The upper address byte has its own pins. The lower address byte shares pins with the data, so external logic catches it with the latch pulse. Between transactions the sequencer can give the bus to another master. On a hold request it floats its pins and raises a grant. A separate reset request pin has to stay low for a minimum number of clocks before it takes effect. Once it does, it aborts any cycle in flight and holds the pins quiet.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_kind` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 port read, 4 port write, 5 interrupt acknowledge, 6 bus idle, with code 7 handled as bus idle. From the first to the last clock state of a cycle, `{io_m,s1,s0}` is 011, 010, 001, 110, 101, 111 and 000 for codes 0 to 6.
- R2: In the first clock state of any cycle except bus idle, `ale` is 1 for exactly that one clock. `ad_oe` is 1 and `ad_out` carries address bits 7:0. `a_hi` carries address bits 15:8, and all strobes are high.
- R3: For port read and port write, the 8-bit port number (address bits 7:0) appears on both `a_hi` and `ad_out` in the first state.
- R4: For opcode fetch, memory read and port read, `ad_oe` is 0 from the second state on. `rd_n` is 0 in the second state and in every wait state, and 1 in the third. The `ad_in` byte present in the last strobe clock comes out on `rd_data`, with `rd_valid` high for that third state only.
- R5: For memory write and port write, `wr_n` is 0 in the second state and every wait state. `ad_oe` stays 1 with `ad_out` equal to the write byte from the second state through the third.
- R6: Interrupt acknowledge uses `inta_n` in place of `rd_n` with the same timing and data capture. `rd_n` stays high.
- R7: Opcode fetch takes four clock states and all other kinds three, plus wait states. One idle clock follows every cycle, and `req_take` is high only in an idle clock in which `req_valid` is accepted.
- R8: `ready` is sampled at the end of the second state and of each wait state, and each low sample adds one wait state. A bus idle cycle ignores `ready`, gives no `ale` pulse and asserts no strobe.
- R9: `hold` is honoured only in an idle clock and wins over a pending request. From the next clock on, `hlda` is 1 and `ad_oe`, `a_hi_oe` and `ctl_oe` are 0. The clock after `hold` is seen low, the bus is idle again.
- R10: `rst_out` rises only after `rst_req_n` has been sampled low on 4 consecutive clock edges. A shorter low pulse has no effect.
- R11: While `rst_out` is 1, the pins show the idle state and no request is taken. A cycle in progress is abandoned, and the sequencer is idle when `rst_out` falls.
- R12: In an idle clock, `{io_m,s1,s0}` is 000, `ale` is 0, all strobes are high, `ad_oe` is 0, and `a_hi_oe`, `ctl_oe` are 1 with `hlda` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| rst_req_n | input | 1 | External reset request, active low, filtered |
| req_valid | input | 1 | Core asks for a bus cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address (port number in bits 7:0 for port cycles) |
| req_wdata | input | 8 | Byte to write |
| req_take | output | 1 | Request accepted this clock |
| rd_data | output | 8 | Byte read by the last read-type cycle |
| rd_valid | output | 1 | `rd_data` is new this clock |
| ready | input | 1 | Slave ready; low adds wait states |
| hold | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Bus granted to the other master |
| rst_out | output | 1 | Filtered reset active |
| ale | output | 1 | Address latch pulse |
| ad_out | output | 8 | Value for the shared address/data pins |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ad_in | input | 8 | Value on the shared pins |
| a_hi | output | 8 | Upper address pins |
| a_hi_oe | output | 1 | Drive enable for the upper address pins |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| io_m | output | 1 | Port (1) or memory (0) select |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ctl_oe | output | 1 | Drive enable for strobes and status |

## Verification
The assertions assume that `hold` and `ready` only change between clock edges. They also assume that `ad_in` is stable while a read strobe is low, and that `rst_n` is pulsed once at start-up before any request. The bench drives every input on the falling edge and changes `ad_in` only before the second state. It raises `hold` and `rst_req_n` changes only from idle clocks or at chosen points in a cycle. These points stay within those assumptions while still reaching the abort-by-reset and hold-deferred-to-cycle-end cases.

// File: rtl/bcs_pkg.sv
// Shared types for the bus cycle sequencer: cycle kinds, clock states,
// status encoding and kind classification helpers.
package bcs_pkg;

    typedef enum logic [2:0] {
        CYC_OPF  = 3'd0,
        CYC_MRD  = 3'd1,
        CYC_MWR  = 3'd2,
        CYC_IORD = 3'd3,
        CYC_IOWR = 3'd4,
        CYC_IACK = 3'd5,
        CYC_IDLE = 3'd6
    } cyc_kind_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TW   = 3'd3,
        TS_T3   = 3'd4,
        TS_T4   = 3'd5,
        TS_HOLD = 3'd6
    } tstate_e;

    typedef struct packed {
        logic io_sel;
        logic st1;
        logic st0;
    } status_t;

    // Status pin code for each cycle kind
    function automatic status_t status_of(cyc_kind_e k);
        case (k)
            CYC_OPF:  return '{1'b0, 1'b1, 1'b1};
            CYC_MRD:  return '{1'b0, 1'b1, 1'b0};
            CYC_MWR:  return '{1'b0, 1'b0, 1'b1};
            CYC_IORD: return '{1'b1, 1'b1, 1'b0};
            CYC_IOWR: return '{1'b1, 1'b0, 1'b1};
            CYC_IACK: return '{1'b1, 1'b1, 1'b1};
            default:  return '{1'b0, 1'b0, 1'b0};
        endcase
    endfunction

    // Kinds that take a byte in from the shared pins
    function automatic logic is_read(cyc_kind_e k);
        return (k == CYC_OPF) || (k == CYC_MRD) || (k == CYC_IORD) || (k == CYC_IACK);
    endfunction

    // Kinds that drive a byte out on the shared pins
    function automatic logic is_write(cyc_kind_e k);
        return (k == CYC_MWR) || (k == CYC_IOWR);
    endfunction

    // Kinds that address the 8-bit port space
    function automatic logic is_port(cyc_kind_e k);
        return (k == CYC_IORD) || (k == CYC_IOWR);
    endfunction

endpackage

// File: rtl/bcs_reset_filter.sv
// Reset request filter. Counts consecutive low samples of rst_req_n and
// raises rst_out once RST_HOLD of them have been seen; any high sample
// clears the count. Assumes rst_req_n is already synchronous to clk.
module bcs_reset_filter #(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req_n,
    output logic rst_out
);
    localparam int CW = $clog2(RST_HOLD + 1);
    localparam logic [CW-1:0] FULL = CW'(RST_HOLD);

    logic [CW-1:0] low_cnt;

    // Saturating count of consecutive low samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (rst_req_n) begin
            low_cnt <= '0;
        end else if (low_cnt != FULL) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rst_out = (low_cnt == FULL);

    // R10
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> $past(!rst_req_n));

    // R10
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_n |=> !rst_out);

endmodule

// File: rtl/bcs_tstate_fsm.sv
// Clock-state sequencer. Accepts one request per idle clock, latches its
// kind, address and write byte, steps T1-T2-(TW)*-T3[-T4] and enters the
// hold state from idle only. Captures the read byte on the edge that ends
// the last strobe clock. Assumes rst_act is a registered, glitch-free level.
module bcs_tstate_fsm
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_act,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold,
    input  logic [DATA_W-1:0] ad_in,
    output tstate_e           state,
    output cyc_kind_e         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              req_take
);
    cyc_kind_e kind_in;

    // Map the spare code onto bus idle
    always_comb begin
        kind_in = (req_kind == 3'd7) ? CYC_IDLE : cyc_kind_e'(req_kind);
    end

    assign req_take = (state == TS_IDLE) && req_valid && !hold && !rst_act;

    // Advance the clock state and latch request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TS_IDLE;
            kind_q  <= CYC_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (rst_act) begin
            state <= TS_IDLE;
        end else begin
            case (state)
                TS_IDLE: begin
                    if (hold) begin
                        state <= TS_HOLD;
                    end else if (req_valid) begin
                        state   <= TS_T1;
                        kind_q  <= kind_in;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                    end
                end
                TS_T1: state <= TS_T2;
                TS_T2, TS_TW: begin
                    if (kind_q == CYC_IDLE) begin
                        state <= TS_T3;
                    end else if (ready) begin
                        state <= TS_T3;
                        if (is_read(kind_q)) rdata_q <= ad_in;
                    end else begin
                        state <= TS_TW;
                    end
                end
                TS_T3:   state <= (kind_q == CYC_OPF) ? TS_T4 : TS_IDLE;
                TS_T4:   state <= TS_IDLE;
                TS_HOLD: if (!hold) state <= TS_IDLE;
                default: state <= TS_IDLE;
            endcase
        end
    end

    // R8
    wait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_TW) |-> (!$past(ready) && $past(kind_q) != CYC_IDLE));

    // R7
    fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_T4) |-> ($past(state) == TS_T3 && kind_q == CYC_OPF));

    // R9
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_HOLD && $past(state) != TS_HOLD) |-> $past(state) == TS_IDLE);

endmodule

// File: rtl/bcs_pin_drive.sv
// Pin decoder. Turns the current clock state and latched request into
// latch pulse, shared-pin value and enable, upper address, strobes, status
// and drive enables. Purely combinational; forces the idle picture while
// the filtered reset is active.
module bcs_pin_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  tstate_e             state,
    input  cyc_kind_e           kind_q,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic [DATA_W-1:0]   wdata_q,
    input  logic                rst_act,
    output logic                ale,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                a_hi_oe,
    output logic                rd_n,
    output logic                wr_n,
    output logic                inta_n,
    output logic                io_m,
    output logic                s1,
    output logic                s0,
    output logic                ctl_oe,
    output logic                hlda,
    output logic                rd_valid
);
    localparam int HI_W = ADDR_W - DATA_W;

    tstate_e eff;
    logic    in_cycle;
    logic    bi;
    status_t st;

    assign eff      = rst_act ? TS_IDLE : state;
    assign in_cycle = (eff == TS_T1) || (eff == TS_T2) || (eff == TS_TW) ||
                      (eff == TS_T3) || (eff == TS_T4);
    assign bi       = (kind_q == CYC_IDLE);

    // Decode pin levels for the current clock state
    always_comb begin
        ale      = 1'b0;
        ad_out   = '0;
        ad_oe    = 1'b0;
        a_hi     = addr_q[ADDR_W-1:DATA_W];
        a_hi_oe  = 1'b1;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        inta_n   = 1'b1;
        st       = '{1'b0, 1'b0, 1'b0};
        ctl_oe   = 1'b1;
        hlda     = 1'b0;
        rd_valid = 1'b0;
        if (in_cycle) begin
            st = status_of(kind_q);
            if (is_port(kind_q)) a_hi = HI_W'(addr_q[DATA_W-1:0]);
        end
        case (eff)
            TS_T1: begin
                if (!bi) begin
                    ale    = 1'b1;
                    ad_oe  = 1'b1;
                    ad_out = addr_q[DATA_W-1:0];
                end
            end
            TS_T2, TS_TW: begin
                if (is_write(kind_q)) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = wdata_q;
                end else if (kind_q == CYC_IACK) begin
                    inta_n = 1'b0;
                end else if (is_read(kind_q)) begin
                    rd_n = 1'b0;
                end
            end
            TS_T3: begin
                if (is_write(kind_q)) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata_q;
                end else if (is_read(kind_q)) begin
                    rd_valid = 1'b1;
                end
            end
            TS_HOLD: begin
                hlda    = 1'b1;
                a_hi_oe = 1'b0;
                ctl_oe  = 1'b0;
            end
            default: ;
        endcase
    end

    assign io_m = st.io_sel;
    assign s1   = st.st1;
    assign s0   = st.st0;

endmodule

// File: rtl/bus_cycle_seq.sv
// Bus cycle sequencer top. Ties the reset request filter, the clock-state
// sequencer and the pin decoder together. Tri-state is expressed as drive
// enables; the pad ring is assumed to combine ad_out/ad_oe/ad_in.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int RST_HOLD = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rst_req_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_take,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    input  logic                     ready,
    input  logic                     hold,
    output logic                     hlda,
    output logic                     rst_out,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     a_hi_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     inta_n,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     ctl_oe
);
    tstate_e           state;
    cyc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    bcs_reset_filter #(.RST_HOLD(RST_HOLD)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req_n (rst_req_n),
        .rst_out   (rst_out)
    );

    bcs_tstate_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_act   (rst_out),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .hold      (hold),
        .ad_in     (ad_in),
        .state     (state),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rd_data),
        .req_take  (req_take)
    );

    bcs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state    (state),
        .kind_q   (kind_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .rst_act  (rst_out),
        .ale      (ale),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .a_hi     (a_hi),
        .a_hi_oe  (a_hi_oe),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .inta_n   (inta_n),
        .io_m     (io_m),
        .s1       (s1),
        .s0       (s0),
        .ctl_oe   (ctl_oe),
        .hlda     (hlda),
        .rd_valid (rd_valid)
    );

    // R2
    ale_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && inta_n && ad_oe));

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rd_n, !wr_n, !inta_n}) <= 1);

    // R4
    rdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!rd_n || !inta_n));

    // R9
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !a_hi_oe && !ctl_oe));

    // R9
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold));

    // R11
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> (rd_n && wr_n && inta_n && !ale && !req_take && !hlda));

endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n, rst_req_n, req_valid, ready, hold;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, ad_in;
    logic        req_take, rd_valid, hlda, rst_out, ale, ad_oe, a_hi_oe;
    logic        rd_n, wr_n, inta_n, io_m, s1, s0, ctl_oe;
    logic [7:0]  rd_data, ad_out, a_hi;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .rst_req_n(rst_req_n), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_take(req_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .ready(ready), .hold(hold), .hlda(hlda), .rst_out(rst_out),
        .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .a_hi(a_hi), .a_hi_oe(a_hi_oe), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .io_m(io_m), .s1(s1), .s0(s0), .ctl_oe(ctl_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_stat(input int k);
        case (k)
            0: return 3'b011;
            1: return 3'b010;
            2: return 3'b001;
            3: return 3'b110;
            4: return 3'b101;
            5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    // R12: idle picture
    task automatic chk_idle(input string tag);
        chk({tag, " R12 status"}, {io_m, s1, s0}, 3'b000);
        chk({tag, " R12 ale"}, ale, 1'b0);
        chk({tag, " R12 strobes"}, {rd_n, wr_n, inta_n}, 3'b111);
        chk({tag, " R12 enables"}, {ad_oe, a_hi_oe, ctl_oe, hlda}, 4'b0110);
    endtask

    // One full cycle, entered at a falling edge just before the idle clock
    task automatic run_cycle(input int k, input int w, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] rv);
        int  ek;
        bit  bi, rdk, wrk, ia, io;
        int  nw;
        ek  = (k == 7) ? 6 : k;
        bi  = (ek == 6);
        rdk = (ek == 0 || ek == 1 || ek == 3 || ek == 5);
        wrk = (ek == 2 || ek == 4);
        ia  = (ek == 5);
        io  = (ek == 3 || ek == 4);
        nw  = bi ? 0 : w;
        @(negedge clk);
        chk_idle("pre-cycle");
        req_kind = k[2:0]; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        #1 chk("R7 take in idle", req_take, 1'b1);
        @(negedge clk);                              // T1
        req_valid = 1'b0;
        chk("R1 status T1", {io_m, s1, s0}, exp_stat(ek));
        chk("R2/R8 ale T1", ale, !bi);
        chk("R2 strobes T1", {rd_n, wr_n, inta_n}, 3'b111);
        if (!bi) begin
            chk("R2 ad_oe T1", ad_oe, 1'b1);
            chk("R2 low addr", ad_out, addr[7:0]);
            chk(io ? "R3 port on a_hi" : "R2 high addr", a_hi, io ? addr[7:0] : addr[15:8]);
        end
        ad_in = rv;
        for (int i = 0; i <= nw; i++) begin          // T2, then waits
            @(negedge clk);
            chk(ia ? "R6 rd_n idle" : "R4 rd_n", rd_n, !(rdk && !ia));
            chk("R6 inta_n", inta_n, !ia);
            chk("R5 wr_n", wr_n, !wrk);
            chk("R4/R5 ad_oe", ad_oe, wrk);
            if (wrk) chk("R5 write byte", ad_out, wd);
            chk("R1 status T2", {io_m, s1, s0}, exp_stat(ek));
            chk("R7 busy", req_take, 1'b0);
            ready = bi ? 1'b0 : (i == nw);
        end
        @(negedge clk);                              // T3
        ready = 1'b1;
        chk("R8 strobes T3", {rd_n, wr_n, inta_n}, 3'b111);
        chk("R4 rd_valid", rd_valid, rdk);
        if (rdk) chk("R4 read byte", rd_data, rv);
        if (wrk) chk("R5 hold byte T3", {ad_oe, ad_out}, {1'b1, wd});
        chk("R1 status T3", {io_m, s1, s0}, exp_stat(ek));
        if (ek == 0) begin
            @(negedge clk);                          // T4
            chk("R7 T4 rd_valid", rd_valid, 1'b0);
            chk("R7 T4 status", {io_m, s1, s0}, 3'b011);
            chk("R7 T4 ad_oe", ad_oe, 1'b0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rst_req_n = 1'b1; req_valid = 1'b0; ready = 1'b1; hold = 1'b0;
        req_kind = '0; req_addr = '0; req_wdata = '0; ad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("reset");
        chk("R10 rst_out after reset", rst_out, 1'b0);
        chk("R4 rd_valid after reset", rd_valid, 1'b0);

        // Sweep all kind codes against wait counts 0..3
        for (int k = 0; k < 8; k++) begin
            for (int w = 0; w < 4; w++) begin
                run_cycle(k, w, 16'h1000 * k + 16'h0123 * (w + 1),
                          8'hA0 ^ 8'(k * 16 + w), 8'h5C + 8'(k * 7 + w));
            end
        end

        // R9: hold beats a pending request in idle
        @(negedge clk);
        hold = 1'b1; req_valid = 1'b1; req_kind = 3'd1;
        #1 chk("R9 no take under hold", req_take, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 hlda", hlda, 1'b1);
            chk("R9 float", {ad_oe, a_hi_oe, ctl_oe}, 3'b000);
        end
        hold = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk("R9 released", hlda, 1'b0);
        chk_idle("after hold");

        // R9: hold raised mid-cycle is deferred to the idle clock after it
        req_kind = 3'd1; req_addr = 16'h4242; req_valid = 1'b1;
        @(negedge clk);                              // T1
        req_valid = 1'b0; hold = 1'b1;
        @(negedge clk); chk("R9 no grant T2", hlda, 1'b0);
        @(negedge clk); chk("R9 no grant T3", hlda, 1'b0);
        @(negedge clk); chk("R9 no grant idle", hlda, 1'b0);
        @(negedge clk); chk("R9 grant after cycle", hlda, 1'b1);
        hold = 1'b0;
        @(negedge clk); chk("R9 grant dropped", hlda, 1'b0);

        // R10: three low samples are ignored
        rst_req_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 short pulse", rst_out, 1'b0);
        end
        rst_req_n = 1'b1;
        @(negedge clk);
        chk("R10 short pulse end", rst_out, 1'b0);
        run_cycle(2, 0, 16'h2211, 8'h3C, 8'h00);

        // R10/R11: long request aborts a stalled fetch
        @(negedge clk);
        req_kind = 3'd0; req_addr = 16'h8001; req_valid = 1'b1;
        @(negedge clk);                              // T1
        req_valid = 1'b0; ready = 1'b0;
        @(negedge clk);                              // T2
        chk("R11 fetch stalled", rd_n, 1'b0);
        rst_req_n = 1'b0;
        req_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 not yet", rst_out, 1'b0);
            chk("R8 still waiting", rd_n, 1'b0);
        end
        @(negedge clk);
        chk("R10 fourth sample", rst_out, 1'b1);
        chk("R11 strobe dropped", rd_n, 1'b1);
        chk("R11 no take", req_take, 1'b0);
        chk("R11 quiet status", {io_m, s1, s0, ale}, 4'b0000);
        @(negedge clk);
        chk("R11 held quiet", {rst_out, rd_n, ale}, 3'b110);
        rst_req_n = 1'b1; req_valid = 1'b0; ready = 1'b1;
        @(negedge clk);
        chk("R11 released", rst_out, 1'b0);
        chk_idle("after abort");
        run_cycle(3, 1, 16'h00F7, 8'h00, 8'h9E);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule